// File: doc/BRIEF.md
# Accumulator-less I/O Instruction Executor

This block carries out the I/O instruction group of a small 8-bit processor that keeps its addresses in a file of sixteen 16-bit scratchpad registers. When an instruction with high nibble 6 is issued, the block moves one byte directly between data memory and the external data bus. No accumulator sits in that path. The memory byte is addressed by the register that the pointer X selects, written R(X).

An output instruction puts the addressed byte on the bus and then steps R(X) forward by one. A run of outputs therefore walks through consecutive memory bytes. If X names the program counter register, the byte after the opcode goes out and the counter skips over it. An input instruction stores the bus byte at R(X) and leaves the register as it was. The four N bits, an execute-state flag and a transfer strobe are offered to external devices for one clock. External logic uses them to select a channel and to latch or supply data.

The register file and the synchronous byte memory live inside the block. Each has a plain host port, which the fetch and ALU logic of the wider processor would use.

Top module: `ioexec_top`

## Requirements
- R1: During and after reset, until an instruction is accepted, exec_state, io_strobe and bus_oe are 0, io_n is 0, and every scratchpad register reads 16'h0000.
- R2: A start pulse with op_i equal to 4'h6 gives exactly one execute cycle, the clock cycle after the pulse, with exec_state high. A start with any other op_i gives no execute cycle and leaves registers and memory unchanged.
- R3: For N = 1 to 7 (MSB of N is 0), the execute cycle has io_strobe = 1, io_n = N, bus_oe = 1 and bus_out equal to the memory byte at R(X).
- R4: After an output instruction, R(X) reads its old value plus one from the cycle after the execute cycle onward. 16'hFFFF wraps to 16'h0000.
- R5: For N = 8 to F (MSB of N is 1), the execute cycle has io_strobe = 1, io_n = N and bus_oe = 0. The bus_in byte present in that cycle is written to memory at R(X), and R(X) is left unchanged.
- R6: When X selects the register used as program counter, an output sends the byte that register points at and advances it by one.
- R7: N = 0 in the group gives an execute cycle with io_strobe = 0, io_n = 0 and bus_oe = 0. It increments R(X) and leaves memory unchanged.
- R8: A start that arrives during an execute cycle is ignored: there is no second execute cycle and R(X) changes only once.
- R9: Memory is addressed by the low MEM_AW bits of R(X). A host memory read returns the byte one cycle after mem_addr is presented, whenever no start is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction issue pulse |
| op_i | input | 4 | Opcode high nibble |
| op_n | input | 4 | Opcode low nibble |
| ptr_x | input | 4 | Index of the data pointer register |
| exec_state | output | 1 | High during the execute cycle of a group-6 instruction |
| io_strobe | output | 1 | Transfer strobe for external devices |
| io_n | output | 4 | N code presented to devices while strobing |
| bus_out | output | 8 | Byte driven on output transfers |
| bus_oe | output | 1 | bus_out is valid |
| bus_in | input | 8 | Byte supplied by a device on input transfers |
| reg_we | input | 1 | Host register write enable |
| reg_wsel | input | 4 | Host register write index |
| reg_wdata | input | 16 | Host register write data |
| reg_rsel | input | 4 | Host register read index |
| reg_rdata | output | 16 | Host register read data (combinational) |
| mem_we | input | 1 | Host memory write enable |
| mem_addr | input | 8 | Host memory address |
| mem_wdata | input | 8 | Host memory write data |
| mem_rdata | output | 8 | Memory read data, one cycle after address |

## Verification
Suppose the execute stage latches the wrong kind or the wrong pointer value. The error shows at io_strobe, io_n, bus_oe and bus_out in the execute cycle itself, one clock after start. A wrong or missing write-back of R(X) shows on reg_rdata from the very next cycle. A misdirected input write appears only when the affected memory byte is read back, one cycle after its address is presented. A start that is wrongly accepted during an execute cycle shows as exec_state held high for a second cycle, together with a double increment.

// File: rtl/ioexec_pkg.sv
// Package: shared constants and types of the I/O instruction executor.
// Assumes: opcode nibbles are 4 bits wide.
package ioexec_pkg;
    localparam logic [3:0] IO_GROUP = 4'h6;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_OUT  = 2'd1,
        KIND_IN   = 2'd2,
        KIND_INC  = 2'd3
    } io_kind_e;
endpackage

// File: rtl/ioexec_decode.sv
// Decode: classifies an issued instruction and decides whether it is accepted.
// Assumes: a start during the execute cycle (busy) is dropped, not queued.
module ioexec_decode
    import ioexec_pkg::*;
(
    input  logic     start,
    input  logic     busy,
    input  logic [3:0] op_i,
    input  logic [3:0] op_n,
    output logic     accept,
    output io_kind_e kind
);
    // Acceptance: group 6 only, and never on top of a running execute cycle.
    always_comb begin
        accept = start && !busy && (op_i == IO_GROUP);
    end

    // Kind: N=0 is increment only, MSB of N selects the direction otherwise.
    always_comb begin
        if (op_n == 4'h0) begin
            kind = KIND_INC;
        end else if (op_n[3]) begin
            kind = KIND_IN;
        end else begin
            kind = KIND_OUT;
        end
    end
endmodule

// File: rtl/ioexec_regfile.sv
// Register file: NREG scratchpad registers with two read ports and two
// write sources. The execute-stage increment wins over a host write to the
// same register in the same cycle.
// Assumes: reads are combinational; registers clear on reset.
module ioexec_regfile #(
    parameter int NREG = 16,
    parameter int RW   = 16,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_we,
    input  logic [SW-1:0] inc_sel,
    input  logic [RW-1:0] inc_data,
    input  logic          host_we,
    input  logic [SW-1:0] host_sel,
    input  logic [RW-1:0] host_data,
    input  logic [SW-1:0] rsel_a,
    output logic [RW-1:0] rdata_a,
    input  logic [SW-1:0] rsel_b,
    output logic [RW-1:0] rdata_b
);
    logic [RW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Storage: one register, increment write-back taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (inc_we && (inc_sel == SW'(g))) begin
                regs[g] <= inc_data;
            end else if (host_we && (host_sel == SW'(g))) begin
                regs[g] <= host_data;
            end
        end
    end

    // Read ports: plain index selects.
    always_comb begin
        rdata_a = regs[rsel_a];
        rdata_b = regs[rsel_b];
    end
endmodule

// File: rtl/ioexec_mem.sv
// Memory: synchronous byte array with one read and one write port.
// Assumes: read data is registered (one-cycle latency); a read of the
// address being written returns the old byte. Contents are not reset.
module ioexec_mem #(
    parameter int DW = 8,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/ioexec_ctrl.sv
// Control: holds the single execute cycle of an accepted instruction and
// drives the device-side signals, the R(X) write-back and the input write.
// Assumes: mem_q holds M(R(X)) during the execute cycle (read issued at accept).
module ioexec_ctrl
    import ioexec_pkg::*;
#(
    parameter int RW = 16,
    parameter int DW = 8,
    parameter int SW = 4,
    parameter int MAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  io_kind_e       kind,
    input  logic [3:0]     op_n,
    input  logic [SW-1:0]  ptr_x,
    input  logic [RW-1:0]  rx_val,
    input  logic [DW-1:0]  mem_q,
    input  logic [DW-1:0]  bus_in,
    output logic           busy,
    output logic           exec_state,
    output logic           io_strobe,
    output logic [3:0]     io_n,
    output logic [DW-1:0]  bus_out,
    output logic           bus_oe,
    output logic           inc_we,
    output logic [SW-1:0]  inc_sel,
    output logic [RW-1:0]  inc_data,
    output logic           wr_we,
    output logic [MAW-1:0] wr_addr,
    output logic [DW-1:0]  wr_data
);
    logic          ex_vld;
    io_kind_e      ex_kind;
    logic [3:0]    ex_n;
    logic [SW-1:0] ex_x;
    logic [RW-1:0] ex_rx;

    // Execute stage valid: set for exactly the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_vld <= 1'b0;
        end else begin
            ex_vld <= accept;
        end
    end

    // Execute stage payload: captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_kind <= KIND_NONE;
            ex_n    <= '0;
            ex_x    <= '0;
            ex_rx   <= '0;
        end else if (accept) begin
            ex_kind <= kind;
            ex_n    <= op_n;
            ex_x    <= ptr_x;
            ex_rx   <= rx_val;
        end
    end

    // Device side: strobe and N lines only for real transfers.
    always_comb begin
        busy       = ex_vld;
        exec_state = ex_vld;
        io_strobe  = ex_vld && (ex_kind == KIND_OUT || ex_kind == KIND_IN);
        io_n       = io_strobe ? ex_n : 4'h0;
        bus_oe     = ex_vld && (ex_kind == KIND_OUT);
        bus_out    = bus_oe ? mem_q : '0;
    end

    // Write-back: post-increment for output and increment-only kinds.
    always_comb begin
        inc_we   = ex_vld && (ex_kind == KIND_OUT || ex_kind == KIND_INC);
        inc_sel  = ex_x;
        inc_data = ex_rx + RW'(1);
    end

    // Input transfer: bus byte goes to M(R(X)).
    always_comb begin
        wr_we   = ex_vld && (ex_kind == KIND_IN);
        wr_addr = ex_rx[MAW-1:0];
        wr_data = bus_in;
    end
endmodule

// File: rtl/ioexec_top.sv
// Top: I/O instruction executor. Joins decode, register file, memory and
// control. The memory read for M(R(X)) is issued in the accept cycle.
// Assumes: host memory writes yield to an input transfer in the same cycle.
module ioexec_top
    import ioexec_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int RW     = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 8,
    localparam int SW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_i,
    input  logic [3:0]        op_n,
    input  logic [SW-1:0]     ptr_x,
    output logic              exec_state,
    output logic              io_strobe,
    output logic [3:0]        io_n,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe,
    input  logic [DW-1:0]     bus_in,
    input  logic              reg_we,
    input  logic [SW-1:0]     reg_wsel,
    input  logic [RW-1:0]     reg_wdata,
    input  logic [SW-1:0]     reg_rsel,
    output logic [RW-1:0]     reg_rdata,
    input  logic              mem_we,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     mem_rdata
);
    logic              accept;
    logic              busy;
    io_kind_e          kind;
    logic [RW-1:0]     rx_val;
    logic              inc_we;
    logic [SW-1:0]     inc_sel;
    logic [RW-1:0]     inc_data;
    logic              wr_we;
    logic [MEM_AW-1:0] wr_addr;
    logic [DW-1:0]     wr_data;
    logic              m_we;
    logic [MEM_AW-1:0] m_waddr;
    logic [DW-1:0]     m_wdata;
    logic [MEM_AW-1:0] m_raddr;
    logic [DW-1:0]     m_q;

    ioexec_decode u_decode (
        .start  (start),
        .busy   (busy),
        .op_i   (op_i),
        .op_n   (op_n),
        .accept (accept),
        .kind   (kind)
    );

    ioexec_regfile #(.NREG(NREG), .RW(RW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_we    (inc_we),
        .inc_sel   (inc_sel),
        .inc_data  (inc_data),
        .host_we   (reg_we),
        .host_sel  (reg_wsel),
        .host_data (reg_wdata),
        .rsel_a    (ptr_x),
        .rdata_a   (rx_val),
        .rsel_b    (reg_rsel),
        .rdata_b   (reg_rdata)
    );

    // Memory port steering: executor first, host otherwise.
    always_comb begin
        m_raddr = accept ? rx_val[MEM_AW-1:0] : mem_addr;
        m_we    = wr_we || mem_we;
        m_waddr = wr_we ? wr_addr : mem_addr;
        m_wdata = wr_we ? wr_data : mem_wdata;
    end

    ioexec_mem #(.DW(DW), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (m_we),
        .waddr (m_waddr),
        .wdata (m_wdata),
        .raddr (m_raddr),
        .rdata (m_q)
    );

    ioexec_ctrl #(.RW(RW), .DW(DW), .SW(SW), .MAW(MEM_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .kind       (kind),
        .op_n       (op_n),
        .ptr_x      (ptr_x),
        .rx_val     (rx_val),
        .mem_q      (m_q),
        .bus_in     (bus_in),
        .busy       (busy),
        .exec_state (exec_state),
        .io_strobe  (io_strobe),
        .io_n       (io_n),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .inc_we     (inc_we),
        .inc_sel    (inc_sel),
        .inc_data   (inc_data),
        .wr_we      (wr_we),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    assign mem_rdata = m_q;
endmodule

// File: rtl/ioexec_checker.sv
// Checker: port-level properties of the executor, bound to ioexec_top.
// Assumes: synchronous active-low reset on rst_n.
module ioexec_checker
    import ioexec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] op_i,
    input logic       exec_state,
    input logic       io_strobe,
    input logic [3:0] io_n,
    input logic       bus_oe
);
    // R2: an execute cycle follows a group-6 start.
    assert_exec_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_state |-> $past(start && (op_i == IO_GROUP)));

    // R3: a strobe only occurs inside an execute cycle, with N lines active.
    assert_strobe_in_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe |-> (exec_state && (io_n != 4'h0)));

    // R5: the bus is driven only on an output transfer.
    assert_oe_output_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (io_strobe && !io_n[3]));

    // R7: N lines stay quiet outside a strobe.
    assert_nlines_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |-> (io_n == 4'h0));

    // R8: an execute cycle never runs into another.
    assert_single_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_state |=> !exec_state);
endmodule

bind ioexec_top ioexec_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_i       (op_i),
    .exec_state (exec_state),
    .io_strobe  (io_strobe),
    .io_n       (io_n),
    .bus_oe     (bus_oe)
);

// File: tb/ioexec_top_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for ioexec_top, one task each.
module ioexec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_i = '0;
    logic [3:0]  op_n = '0;
    logic [3:0]  ptr_x = '0;
    logic        exec_state;
    logic        io_strobe;
    logic [3:0]  io_n;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  bus_in = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_wsel = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  reg_rsel = '0;
    logic [15:0] reg_rdata;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  mem_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ioexec_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .op_n(op_n),
        .ptr_x(ptr_x), .exec_state(exec_state), .io_strobe(io_strobe),
        .io_n(io_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_reg(input logic [3:0] sel, input logic [15:0] val);
        reg_we = 1'b1; reg_wsel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_mem(input logic [7:0] a, input logic [7:0] d);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic get_reg(input logic [3:0] sel, output logic [15:0] val);
        reg_rsel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic get_mem(input logic [7:0] a, output logic [7:0] d);
        mem_addr = a;
        @(negedge clk);
        d = mem_rdata;
    endtask

    // Issue at a negedge; returns in the following (execute) cycle.
    task automatic issue(input logic [3:0] i, input logic [3:0] n, input logic [3:0] x);
        start = 1'b1; op_i = i; op_n = n; ptr_x = x;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] r;
        check("R1 exec_state", exec_state, 0);
        check("R1 io_strobe", io_strobe, 0);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 io_n", io_n, 0);
        get_reg(4'd5, r);
        check("R1 reg cleared", r, 16'h0000);
    endtask

    task automatic t_output_walk();
        logic [15:0] r;
        set_reg(4'd5, 16'h0010);
        set_mem(8'h10, 8'hA5);
        set_mem(8'h11, 8'h3C);
        issue(4'h6, 4'h3, 4'd5);
        check("R2 exec_state", exec_state, 1);
        check("R3 strobe", io_strobe, 1);
        check("R3 io_n", io_n, 4'h3);
        check("R3 bus_oe", bus_oe, 1);
        check("R3 bus_out", bus_out, 8'hA5);
        @(negedge clk);
        check("R2 single exec", exec_state, 0);
        get_reg(4'd5, r);
        check("R4 post-increment", r, 16'h0011);
        issue(4'h6, 4'h7, 4'd5);
        check("R3 io_n second", io_n, 4'h7);
        check("R4 walk next byte", bus_out, 8'h3C);
        @(negedge clk);
        get_reg(4'd5, r);
        check("R4 second increment", r, 16'h0012);
    endtask

    task automatic t_input();
        logic [15:0] r;
        logic [7:0] d;
        set_reg(4'd6, 16'h0020);
        set_mem(8'h20, 8'h00);
        bus_in = 8'h5E;
        issue(4'h6, 4'hB, 4'd6);
        check("R5 strobe", io_strobe, 1);
        check("R5 io_n", io_n, 4'hB);
        check("R5 bus_oe low", bus_oe, 0);
        @(negedge clk);
        bus_in = 8'h00;
        get_reg(4'd6, r);
        check("R5 R(X) unchanged", r, 16'h0020);
        get_mem(8'h20, d);
        check("R5 byte stored", d, 8'h5E);
    endtask

    task automatic t_inc_only();
        logic [15:0] r;
        logic [7:0] d;
        set_reg(4'd7, 16'h0030);
        set_mem(8'h30, 8'h77);
        issue(4'h6, 4'h0, 4'd7);
        check("R7 exec_state", exec_state, 1);
        check("R7 no strobe", io_strobe, 0);
        check("R7 io_n quiet", io_n, 0);
        check("R7 no bus_oe", bus_oe, 0);
        @(negedge clk);
        get_reg(4'd7, r);
        check("R7 increment", r, 16'h0031);
        get_mem(8'h30, d);
        check("R7 memory kept", d, 8'h77);
    endtask

    task automatic t_immediate();
        logic [15:0] r;
        set_reg(4'd3, 16'h0040);
        set_mem(8'h40, 8'h99);
        issue(4'h6, 4'h2, 4'd3);
        check("R6 immediate byte", bus_out, 8'h99);
        @(negedge clk);
        get_reg(4'd3, r);
        check("R6 counter advanced", r, 16'h0041);
    endtask

    task automatic t_wrap();
        logic [15:0] r;
        set_reg(4'd8, 16'hFFFF);
        set_mem(8'hFF, 8'hC3);
        issue(4'h6, 4'h1, 4'd8);
        check("R9 low address bits", bus_out, 8'hC3);
        @(negedge clk);
        get_reg(4'd8, r);
        check("R4 wrap", r, 16'h0000);
    endtask

    task automatic t_other_group();
        logic [15:0] r;
        set_reg(4'd9, 16'h0050);
        issue(4'h3, 4'h1, 4'd9);
        check("R2 other group no exec", exec_state, 0);
        check("R2 other group no strobe", io_strobe, 0);
        @(negedge clk);
        get_reg(4'd9, r);
        check("R2 other group reg kept", r, 16'h0050);
    endtask

    task automatic t_overlap();
        logic [15:0] r;
        set_reg(4'd10, 16'h0060);
        set_mem(8'h60, 8'h11);
        set_mem(8'h61, 8'h22);
        start = 1'b1; op_i = 4'h6; op_n = 4'h1; ptr_x = 4'd10;
        @(negedge clk);
        check("R8 first exec byte", bus_out, 8'h11);
        @(negedge clk);
        start = 1'b0;
        check("R8 no second exec", exec_state, 0);
        check("R8 no second strobe", io_strobe, 0);
        @(negedge clk);
        get_reg(4'd10, r);
        check("R8 single increment", r, 16'h0061);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output_walk();
        t_input();
        t_inc_only();
        t_immediate();
        t_wrap();
        t_other_group();
        t_overlap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule